// File: doc/BRIEF.md
# Hiccup Fault Controller for a Switching Regulator

This block sequences a switching regulator through off, soft-start, run and a cool-down pause. Two 3-bit fault counters protect it, both evaluated once per switching cycle. The first counts cycles in which a hysteretic under-voltage flag is raised. The second counts cycles in which the sampled switch current code lies above a limit, and that limit grows with the number of power stages fitted.

When either counter runs out, the regulator is shut down and the cause is recorded. The controller then waits for a fixed number of switching cycles, equal to the nominal soft-start length, before it starts a fresh soft-start. This retry repeats for as long as the fault persists and ends only when a soft-start completes.

Every pin is a plain control or status level. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure. All inputs are sampled synchronously on the rising edge of `clk`. The counters and the cool-down timer advance only in cycles where `cyc_tick` is high.

Top module: `hiccup_ctrl`

## Requirements
- R1: While reset is held, and in every cycle after a rising clock edge at which `enable` was low, `run_en`=0, `ss_req`=0 and `fault_code`=2'b00.
- R2: With the controller off, a clock edge that samples `enable`=1 makes `ss_req`=1 and `run_en`=1 from the next cycle on (soft-start).
- R3: During soft-start, an edge that samples `ss_done`=1 with no fault firing moves the controller to run: `ss_req`=0 and `run_en`=1 from the next cycle.
- R4: While the regulator runs (soft-start or run), a tick with `uv_flag`=1 increments the under-voltage count and a tick with `uv_flag`=0 clears it. A trip on a tick when the count is already 7 (overflow, the 8th consecutive trip) shuts the regulator down.
- R5: The current limit is `stages`*OC_STEP code units (default 16 per stage). A tick whose `isense` is strictly above the limit increments the overcurrent count, and a tick whose `isense` is at or below the limit clears it. The tick on which the count reaches 7 (the 7th consecutive over-limit sample) shuts the regulator down.
- R6: At the edge that samples the shutting-down tick, `run_en` and `ss_req` fall in the following cycle. `fault_code` then holds bit0 = under-voltage and bit1 = overcurrent (2'b11 if both fire on the same tick), and keeps that value until the next shutdown or until `enable` falls.
- R7: After a shutdown, `run_en` stays 0 for exactly SS_TICKS ticks. The edge that samples the last of them starts a new soft-start (`ss_req`=1). Both counters are zero on entry to the cool-down.
- R8: The counters stay active during soft-start, so a persisting fault must fill a counter again before each new shutdown. The shutdown and retry cycle repeats without limit.
- R9: Sampling `enable`=0 forces the off state from any state and clears both counters and `fault_code`. After re-enable, a full count is needed again before a shutdown.
- R10: In cycles with `cyc_tick`=0, `uv_flag` and `isense` have no effect, and the cool-down timer does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Regulator enable; low forces the off state |
| cyc_tick | input | 1 | One-cycle marker of a switching-cycle boundary |
| uv_flag | input | 1 | Hysteretic under-voltage comparator output, high = under-voltage |
| isense | input | ISW (8) | Sampled switch current code |
| stages | input | STW (3) | Number of power stages fitted |
| ss_done | input | 1 | Soft-start finished status |
| run_en | output | 1 | Regulator switching enable |
| ss_req | output | 1 | Soft-start request |
| fault_code | output | 2 | Cause of the last shutdown: bit0 under-voltage, bit1 overcurrent |

## Verification
The embedded properties assume that `enable`, `cyc_tick`, `uv_flag`, `isense`, `stages` and `ss_done` are synchronous to `clk`, and that `stages` is non-zero while the regulator runs. They place no limit on how ticks are spaced. The stimulus changes every input only at the falling clock edge. It draws `stages` from 1 to 7 and places `isense` within a few codes of the resulting limit, so that both counters fill and clear often. It drops `enable` only rarely, so that long fault runs and complete retry loops take place.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_SOFT = 2'd1,
    SEQ_RUN  = 2'd2,
    SEQ_COOL = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic oc;
    logic uv;
  } fault_cause_t;
endpackage

// File: rtl/fault_counter.sv
module fault_counter #(
  parameter int CNT_W        = 3,
  parameter bit FIRE_ON_WRAP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             hit,
  output logic             fire,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_TOP - 1'b1;

  generate
    if (FIRE_ON_WRAP) begin : g_wrap
      // fires on the trip that would carry out of the full count
      assign fire = tick & hit & (cnt == CNT_TOP);
    end else begin : g_reach
      // fires on the trip that makes the count reach all ones
      assign fire = tick & hit & (cnt == CNT_PRE);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (tick && hit)  cnt <= (cnt == CNT_TOP) ? CNT_TOP : cnt + 1'b1;
    else if (tick)         cnt <= '0;
  end

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R7
  AST_FIRE_NEAR_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (cnt >= CNT_PRE)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt)); // R10
endmodule

// File: rtl/oc_compare.sv
module oc_compare #(
  parameter int ISW     = 8,
  parameter int STW     = 3,
  parameter int OC_STEP = 16
) (
  input  logic [ISW-1:0] isense,
  input  logic [STW-1:0] stages,
  output logic           over
);
  localparam int LIM_W = ISW + STW;
  localparam logic [LIM_W-1:0] STEP_W = LIM_W'(OC_STEP);

  logic [LIM_W-1:0] limit;
  logic [LIM_W-1:0] sample;

  always_comb begin
    limit  = LIM_W'(stages) * STEP_W;
    sample = LIM_W'(isense);
    over   = (sample > limit);
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import hiccup_pkg::*;
#(
  parameter int SS_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       tick,
  input  logic       ss_done,
  input  logic       uv_fire,
  input  logic       oc_fire,
  output logic       active,
  output logic       run_en,
  output logic       ss_req,
  output logic [1:0] fault_code
);
  localparam int DLY_W = $clog2(SS_TICKS + 1);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(SS_TICKS - 1);

  seq_state_t       state;
  logic [DLY_W-1:0] dly;
  fault_cause_t     cause;
  logic             any_fire;

  assign any_fire   = uv_fire | oc_fire;
  assign active     = (state == SEQ_SOFT) || (state == SEQ_RUN);
  assign run_en     = active;
  assign ss_req     = (state == SEQ_SOFT);
  assign fault_code = cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_OFF;
      dly   <= '0;
      cause <= '0;
    end else if (!enable) begin
      state <= SEQ_OFF;
      dly   <= '0;
      cause <= '0;
    end else begin
      unique case (state)
        SEQ_OFF: state <= SEQ_SOFT;
        SEQ_SOFT, SEQ_RUN: begin
          if (any_fire) begin
            state    <= SEQ_COOL;
            dly      <= '0;
            cause.uv <= uv_fire;
            cause.oc <= oc_fire;
          end else if (state == SEQ_SOFT && ss_done) begin
            state <= SEQ_RUN;
          end
        end
        SEQ_COOL: begin
          if (tick) begin
            if (dly == DLY_LAST) begin
              dly   <= '0;
              state <= SEQ_SOFT;
            end else begin
              dly <= dly + 1'b1;
            end
          end
        end
        default: state <= SEQ_OFF;
      endcase
    end
  end

  AST_EN_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!run_en && !ss_req && fault_code == 2'b00)); // R9
  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && active && any_fire) |=> (!run_en && fault_code != 2'b00)); // R6
  AST_COOL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == SEQ_COOL && tick && dly == DLY_LAST) |=> ss_req); // R7
  AST_COOL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == SEQ_COOL && !tick) |=> (state == SEQ_COOL && $stable(dly))); // R10
  AST_SOFT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == SEQ_SOFT && ss_done && !any_fire) |=> (run_en && !ss_req)); // R3
endmodule

// File: rtl/hiccup_ctrl.sv
module hiccup_ctrl #(
  parameter int ISW      = 8,
  parameter int STW      = 3,
  parameter int OC_STEP  = 16,
  parameter int CNT_W    = 3,
  parameter int SS_TICKS = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           cyc_tick,
  input  logic           uv_flag,
  input  logic [ISW-1:0] isense,
  input  logic [STW-1:0] stages,
  input  logic           ss_done,
  output logic           run_en,
  output logic           ss_req,
  output logic [1:0]     fault_code
);
  logic             active;
  logic             oc_over;
  logic             uv_fire;
  logic             oc_fire;
  logic             cnt_clr;
  logic [CNT_W-1:0] uv_cnt;
  logic [CNT_W-1:0] oc_cnt;

  assign cnt_clr = !enable || !active || uv_fire || oc_fire;

  oc_compare #(.ISW(ISW), .STW(STW), .OC_STEP(OC_STEP)) u_cmp (
    .isense (isense),
    .stages (stages),
    .over   (oc_over)
  );

  fault_counter #(.CNT_W(CNT_W), .FIRE_ON_WRAP(1'b1)) u_uv_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .tick  (cyc_tick),
    .hit   (uv_flag),
    .fire  (uv_fire),
    .cnt   (uv_cnt)
  );

  fault_counter #(.CNT_W(CNT_W), .FIRE_ON_WRAP(1'b0)) u_oc_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .tick  (cyc_tick),
    .hit   (oc_over),
    .fire  (oc_fire),
    .cnt   (oc_cnt)
  );

  seq_fsm #(.SS_TICKS(SS_TICKS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .tick       (cyc_tick),
    .ss_done    (ss_done),
    .uv_fire    (uv_fire),
    .oc_fire    (oc_fire),
    .active     (active),
    .run_en     (run_en),
    .ss_req     (ss_req),
    .fault_code (fault_code)
  );

  AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> $past(enable)); // R1
  AST_SS_IMPLIES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ss_req |-> run_en); // R2
  AST_OC_CLEAR_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_tick && !oc_over) |=> (oc_cnt == '0)); // R5
  AST_UV_CLEAR_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_tick && !uv_flag) |=> (uv_cnt == '0)); // R4
endmodule

// File: tb/hiccup_ctrl_test.sv
module hiccup_ctrl_test;
  localparam int ISW = 8;
  localparam int STW = 3;
  localparam int OC_STEP = 16;
  localparam int SS_TICKS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic cyc_tick = 1'b0;
  logic uv_flag = 1'b0;
  logic [ISW-1:0] isense = '0;
  logic [STW-1:0] stages = 3'd3;
  logic ss_done = 1'b0;
  logic run_en;
  logic ss_req;
  logic [1:0] fault_code;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state: 0 off, 1 soft-start, 2 run, 3 cool-down
  int m_st = 0, m_uv = 0, m_oc = 0, m_dly = 0, m_fc = 0;

  always #4 clk = ~clk;

  hiccup_ctrl uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cyc_tick(cyc_tick),
    .uv_flag(uv_flag), .isense(isense), .stages(stages), .ss_done(ss_done),
    .run_en(run_en), .ss_req(ss_req), .fault_code(fault_code)
  );

  function automatic int oc_limit(input int stg);
    return stg * OC_STEP;
  endfunction

  function automatic int exp_out(input int st, input int fc);
    int r = (st == 1 || st == 2) ? 1 : 0;
    r = r | ((st == 1) ? 2 : 0);
    return r | (fc << 2);
  endfunction

  task automatic model_update();
    bit uvf, ocf, over;
    if (!enable) begin
      m_st = 0; m_uv = 0; m_oc = 0; m_dly = 0; m_fc = 0;
    end else if (m_st == 0) begin
      m_st = 1;
    end else if (m_st == 1 || m_st == 2) begin
      over = (int'(isense) > oc_limit(int'(stages)));
      uvf = cyc_tick && uv_flag && (m_uv == 7);
      ocf = cyc_tick && over && (m_oc == 6);
      if (uvf || ocf) begin
        m_st = 3; m_uv = 0; m_oc = 0; m_dly = 0;
        m_fc = (ocf ? 2 : 0) | (uvf ? 1 : 0);
      end else begin
        if (cyc_tick) begin
          m_uv = uv_flag ? ((m_uv == 7) ? 7 : m_uv + 1) : 0;
          m_oc = over ? m_oc + 1 : 0;
        end
        if (m_st == 1 && ss_done) m_st = 2;
      end
    end else begin
      if (cyc_tick) begin
        if (m_dly == SS_TICKS - 1) begin m_dly = 0; m_st = 1; end
        else m_dly = m_dly + 1;
      end
    end
  endtask

  task automatic compare(input string tag);
    int e = exp_out(m_st, m_fc);
    int a = {28'd0, fault_code, ss_req, run_en};
    checks++;
    if (a != e) begin
      fails++;
      $display("FAIL %s: {fault_code,ss_req,run_en} actual=%b expected=%b at %0t",
               tag, a[3:0], e[3:0], $time);
    end
  endtask

  // one clock: inputs already set at the falling edge, model follows the rising edge
  task automatic step(input bit en, input bit tk, input bit uv, input int is,
                      input int stg, input bit sd, input string tag);
    @(negedge clk);
    enable = en; cyc_tick = tk; uv_flag = uv; isense = ISW'(is);
    stages = STW'(stg); ss_done = sd;
    @(posedge clk);
    model_update();
    #1;
    compare(tag);
  endtask

  task automatic expect_bits(input bit r, input bit s, input int fc, input string tag);
    checks++;
    if (run_en !== r || ss_req !== s || fault_code !== 2'(fc)) begin
      fails++;
      $display("FAIL %s: run_en=%b ss_req=%b fault_code=%b expected %b %b %b",
               tag, run_en, ss_req, fault_code, r, s, 2'(fc));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init = $urandom(32'd2024);
    if (seed_init == 0) seed_init = 1;
    repeat (3) @(negedge clk);
    #1 expect_bits(1'b0, 1'b0, 0, "R1 during reset");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 1, 1, 200, 3, 1, "R1");
    expect_bits(1'b0, 1'b0, 0, "R1 enable low");

    step(1, 0, 0, 0, 3, 0, "R2");
    expect_bits(1'b1, 1'b1, 0, "R2 soft-start entered");
    step(1, 0, 0, 0, 3, 1, "R3");
    expect_bits(1'b1, 1'b0, 0, "R3 run entered");

    // under-voltage: 7 trips, clear, 7 trips, then overflow
    for (int i = 0; i < 7; i++) step(1, 1, 1, 0, 3, 0, "R4");
    expect_bits(1'b1, 1'b0, 0, "R4 seven trips tolerated");
    step(1, 1, 0, 0, 3, 0, "R4 clear");
    for (int i = 0; i < 7; i++) step(1, 1, 1, 0, 3, 0, "R4");
    // non-tick cycles with faults present change nothing
    for (int i = 0; i < 5; i++) step(1, 0, 1, 255, 3, 0, "R10");
    step(1, 1, 1, 0, 3, 0, "R4 overflow");
    expect_bits(1'b0, 1'b0, 1, "R6 uv shutdown");

    // cool-down: SS_TICKS ticks, mixed with idle cycles
    for (int i = 0; i < SS_TICKS - 1; i++) begin
      step(1, 1, 1, 255, 3, 1, "R7");
      step(1, 0, 0, 0, 3, 1, "R10");
    end
    expect_bits(1'b0, 1'b0, 1, "R7 still cooling");
    step(1, 1, 0, 0, 3, 0, "R7 exit");
    expect_bits(1'b1, 1'b1, 1, "R7 retry soft-start");

    // overcurrent in soft-start, limit 48 for three stages
    for (int i = 0; i < 6; i++) step(1, 1, 0, 49, 3, 0, "R5");
    step(1, 1, 0, 48, 3, 0, "R5 at limit clears");
    for (int i = 0; i < 6; i++) step(1, 1, 0, 49, 3, 0, "R5");
    expect_bits(1'b1, 1'b1, 1, "R5 six samples tolerated");
    step(1, 1, 0, 49, 3, 0, "R5 seventh");
    expect_bits(1'b0, 1'b0, 2, "R6 oc shutdown");

    // endless retry with a persisting overcurrent (one stage, limit 16)
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < SS_TICKS; i++) step(1, 1, 0, 17, 1, 0, "R8 cool");
      for (int i = 0; i < 7; i++) step(1, 1, 0, 17, 1, 0, "R8 refill");
      expect_bits(1'b0, 1'b0, 2, "R8 repeated shutdown");
    end
    for (int i = 0; i < SS_TICKS; i++) step(1, 1, 0, 0, 1, 0, "R8 cool");
    step(1, 1, 0, 0, 1, 1, "R8 recovered");
    expect_bits(1'b1, 1'b0, 2, "R8 run after retry");

    // both counters finish on the same tick
    step(1, 1, 1, 0, 2, 0, "R6");
    for (int i = 0; i < 7; i++) step(1, 1, 1, 33, 2, 0, "R6 both");
    expect_bits(1'b0, 1'b0, 3, "R6 both causes");

    // disable during cool-down, then counts start from zero
    step(0, 1, 1, 0, 2, 0, "R9");
    expect_bits(1'b0, 1'b0, 0, "R9 disabled");
    step(1, 0, 0, 0, 2, 1, "R9");
    step(1, 0, 0, 0, 2, 1, "R9");
    for (int i = 0; i < 6; i++) step(1, 1, 0, 40, 2, 0, "R9 oc");
    step(0, 1, 0, 40, 2, 0, "R9 drop");
    step(1, 0, 0, 0, 2, 0, "R9");
    for (int i = 0; i < 6; i++) step(1, 1, 0, 40, 2, 0, "R9 recount");
    expect_bits(1'b1, 1'b1, 0, "R9 counter was cleared");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int stg = 1 + int'($urandom_range(6));
      int is = oc_limit(stg) - 2 + int'($urandom_range(4));
      bit en = ($urandom_range(127) != 0);
      bit tk = ($urandom_range(3) != 0);
      bit uv = ($urandom_range(9) < 8);
      bit sd = ($urandom_range(15) == 0);
      step(en, tk, uv, is, stg, sd, "RND");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule